// File: doc/BRIEF.md
# Prioritised Interrupt Request and Acknowledge Unit

This block lets an expansion card raise interrupts on a host processor bus that has only three external request lines. They sit at priority levels 7 (non-maskable), 5 and 3. Internal event sources on the card pulse a per-level set input. The block then holds a pending flag for that level and drives the matching active-low request line. The host resolves the priority between levels. When several requests are asserted together it acknowledges level 7 first, then 5, then 3. The card has to serve every acknowledge cycle for the interrupts it raised itself.

An acknowledge cycle is a bus cycle with function code 3'b111 and the address strobe low. The level being acknowledged appears on address bits A3..A1. Each level has its own mode bit, set through a plain configuration port. In vectored mode the block returns an 8-bit vector number on the low data byte and asserts data acknowledge. In auto-vector mode it asserts valid-peripheral-address, so the processor generates the vector. When the strobe of a served cycle returns high, the block clears that level's pending flag and negates its request line.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset all three request lines, data acknowledge and valid-peripheral-address are high, and the data enable is low.
- R2: A one-cycle pulse on evt_set_i bit i sets that level's pending flag, and the matching irq_n_o bit is low from the next clock edge on. Bit 2 is level 7, bit 1 is level 5 and bit 0 is level 3. All three lines may be low at the same time.
- R3: An acknowledge is recognised only when fc_i equals 3'b111 and as_n_i is low. addr_lvl_i values 3'b111, 3'b101 and 3'b011 select slots 2, 1 and 0. Any other function code or level value leaves every response output inactive.
- R4: The block answers only if the selected level is pending at the clock edge where as_n_i is first sampled low. Otherwise it stays silent for the whole strobe, even if the level becomes pending while the strobe is still low.
- R5: In vectored mode (auto_mode_i bit i = 0), a served cycle holds vpa_n_o high. Whenever lds_n_i is low, the block drives data_o with vec_cfg_i[8*i+7:8*i], sets data_oe_o and pulls dtack_n_o low. dtack_n_o is never low while lds_n_i is high.
- R6: In auto-vector mode (auto_mode_i bit i = 1), vpa_n_o goes low from the first clock edge after the strobe fall. dtack_n_o stays high and data_oe_o stays low.
- R7: At the first clock edge that samples as_n_i high after a served cycle, the served level's pending flag clears and its irq_n_o bit returns high. The other levels keep their state.
- R8: If an event pulse for a level coincides with the clock edge that clears that level, the level stays pending.
- R9: dtack_n_o and vpa_n_o are never low together, and both are high after the clock edge that samples the strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 3 | Per-level event pulses (bit 2 = level 7, bit 1 = level 5, bit 0 = level 3) |
| auto_mode_i | input | 3 | Per-level mode, 1 = auto-vector, 0 = vectored |
| vec_cfg_i | input | 24 | Vector numbers, slot i in bits 8*i+7..8*i |
| fc_i | input | 3 | Function code of the current bus cycle |
| as_n_i | input | 1 | Address strobe, active low |
| addr_lvl_i | input | 3 | Address bits A3..A1, the level being acknowledged |
| lds_n_i | input | 1 | Lower data strobe, active low |
| irq_n_o | output | 3 | Active-low interrupt request lines |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| vpa_n_o | output | 1 | Valid peripheral address (auto-vector request), active low |
| data_o | output | 8 | Vector number for D7..D0 |
| data_oe_o | output | 1 | Enable for data_o onto the data bus |

## Verification
The request lines move one clock edge after an event pulse. The bench therefore drives each pulse on a falling edge and compares irq_n_o at the next falling edge. The decision to answer an acknowledge is taken at the first rising edge that sees the strobe low. The vpa_n_o response is sampled at the falling edge after that. dtack_n_o and the vector follow lds_n_i combinationally while the unit is serving, so they are sampled one half-cycle after the lower strobe is driven. Clearing happens at the edge that samples the strobe high, and the bench checks the request lines and the negated handshake at the falling edge just after it.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int NUM_LVL = 3;
    localparam int VEC_W   = 8;
    localparam int LVL_W   = 3;
    localparam logic [2:0] FC_IACK = 3'b111;

    typedef enum logic {
        RSP_IDLE,
        RSP_BUSY
    } rsp_state_e;

    // Slot i answers level 2*i+3: slot 0 -> 3, slot 1 -> 5, slot 2 -> 7.
    function automatic logic [LVL_W-1:0] slot_level(input int slot);
        return LVL_W'(2 * slot + 3);
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    // A set arriving on the same edge as a clear wins.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr_i[i]) st_d.pend[i] = 1'b0;
            if (set_i[i]) st_d.pend[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_iack_decode.sv
module irq_iack_decode
    import irq_ack_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [2:0]       fc_i,
    input  logic             as_n_i,
    input  logic [LVL_W-1:0] addr_lvl_i,
    output logic [N-1:0]     hit_o
);

    logic iack_cycle;

    assign iack_cycle = (fc_i == FC_IACK) && !as_n_i;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign hit_o[g] = iack_cycle && (addr_lvl_i == slot_level(g));
    end

endmodule

// File: rtl/irq_resp_ctrl.sv
module irq_resp_ctrl
    import irq_ack_pkg::*;
#(
    parameter int N     = 3,
    parameter int VW    = 8,
    parameter int SEL_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    hit_i,
    input  logic [N-1:0]    pend_i,
    input  logic            as_n_i,
    input  logic            lds_n_i,
    input  logic [N-1:0]    auto_i,
    input  logic [N*VW-1:0] vec_i,
    output logic            busy_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [N-1:0]    clr_o,
    output logic            dtack_n_o,
    output logic            vpa_n_o,
    output logic [VW-1:0]   data_o,
    output logic            data_oe_o
);

    typedef struct packed {
        rsp_state_e       state;
        logic [SEL_W-1:0] sel;
        logic             as_n;
    } rsp_t;

    rsp_t st_d, st_q;
    logic [N-1:0]  take;
    logic          sel_auto;
    logic [VW-1:0] sel_vec;
    logic          drive;

    assign take = hit_i & pend_i;

    always_comb begin
        st_d      = st_q;
        st_d.as_n = as_n_i;
        clr_o     = '0;
        unique case (st_q.state)
            RSP_IDLE: begin
                // Decide only on the strobe's falling edge.
                if (st_q.as_n && !as_n_i && (|take)) begin
                    st_d.state = RSP_BUSY;
                    for (int i = 0; i < N; i++) begin
                        if (take[i]) st_d.sel = SEL_W'(i);
                    end
                end
            end
            RSP_BUSY: begin
                if (as_n_i) begin
                    st_d.state = RSP_IDLE;
                    for (int i = 0; i < N; i++) begin
                        if (st_q.sel == SEL_W'(i)) clr_o[i] = 1'b1;
                    end
                end
            end
            default: st_d.state = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: RSP_IDLE, sel: '0, as_n: 1'b1};
        else        st_q <= st_d;
    end

    always_comb begin
        sel_auto = 1'b0;
        sel_vec  = '0;
        for (int i = 0; i < N; i++) begin
            if (st_q.sel == SEL_W'(i)) begin
                sel_auto = auto_i[i];
                sel_vec  = vec_i[i*VW +: VW];
            end
        end
    end

    assign busy_o    = (st_q.state == RSP_BUSY);
    assign sel_o     = st_q.sel;
    assign drive     = busy_o && !sel_auto && !lds_n_i;
    assign vpa_n_o   = !(busy_o && sel_auto);
    assign dtack_n_o = !drive;
    assign data_oe_o = drive;
    assign data_o    = drive ? sel_vec : '0;

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NUM_LVL = irq_ack_pkg::NUM_LVL,
    parameter int VEC_W   = irq_ack_pkg::VEC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LVL-1:0]       evt_set_i,
    input  logic [NUM_LVL-1:0]       auto_mode_i,
    input  logic [NUM_LVL*VEC_W-1:0] vec_cfg_i,
    input  logic [2:0]               fc_i,
    input  logic                     as_n_i,
    input  logic [2:0]               addr_lvl_i,
    input  logic                     lds_n_i,
    output logic [NUM_LVL-1:0]       irq_n_o,
    output logic                     dtack_n_o,
    output logic                     vpa_n_o,
    output logic [VEC_W-1:0]         data_o,
    output logic                     data_oe_o
);

    localparam int SEL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

    logic [NUM_LVL-1:0] pend;
    logic [NUM_LVL-1:0] hit;
    logic [NUM_LVL-1:0] clr;
    logic               busy;
    logic [SEL_W-1:0]   rsp_sel;

    irq_pend_bank #(.N(NUM_LVL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_iack_decode #(.N(NUM_LVL)) u_dec (
        .fc_i       (fc_i),
        .as_n_i     (as_n_i),
        .addr_lvl_i (addr_lvl_i),
        .hit_o      (hit)
    );

    irq_resp_ctrl #(.N(NUM_LVL), .VW(VEC_W), .SEL_W(SEL_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .pend_i    (pend),
        .as_n_i    (as_n_i),
        .lds_n_i   (lds_n_i),
        .auto_i    (auto_mode_i),
        .vec_i     (vec_cfg_i),
        .busy_o    (busy),
        .sel_o     (rsp_sel),
        .clr_o     (clr),
        .dtack_n_o (dtack_n_o),
        .vpa_n_o   (vpa_n_o),
        .data_o    (data_o),
        .data_oe_o (data_oe_o)
    );

    assign irq_n_o = ~pend;

endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
    parameter int NUM_LVL = 3,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_LVL-1:0] irq_n,
    input logic               dtack_n,
    input logic               vpa_n,
    input logic               data_oe,
    input logic               lds_n,
    input logic               busy,
    input logic [SEL_W-1:0]   sel
);

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !vpa_n)); // R9

    AST_DTACK_NEEDS_LDS: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !lds_n); // R5

    AST_AUTO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !vpa_n |-> !data_oe); // R6

    AST_SERVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(irq_n != '1)); // R4

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_clr
        AST_CLEAR_AFTER_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_n[g]) |-> $past(busy && (sel == SEL_W'(g)))); // R7
    end

endmodule

bind irq_ack_unit irq_ack_unit_chk #(.NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_n   (irq_n_o),
    .dtack_n (dtack_n_o),
    .vpa_n   (vpa_n_o),
    .data_oe (data_oe_o),
    .lds_n   (lds_n_i),
    .busy    (busy),
    .sel     (rsp_sel)
);

// File: tb/irq_ack_unit_tb.sv
`timescale 1ns/1ps
module irq_ack_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt = '0;
    logic [2:0]  am = '0;
    logic [23:0] vc = '0;
    logic [2:0]  fc = '0;
    logic        as_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        lds_n = 1'b1;
    logic [2:0]  irq_n;
    logic        dtack_n, vpa_n, data_oe;
    logic [7:0]  data;

    logic [2:0]  pm = '0;   // bench model of pending flags
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_ack_unit u_dut (
        .clk (clk), .rst_n (rst_n), .evt_set_i (evt), .auto_mode_i (am),
        .vec_cfg_i (vc), .fc_i (fc), .as_n_i (as_n), .addr_lvl_i (addr),
        .lds_n_i (lds_n), .irq_n_o (irq_n), .dtack_n_o (dtack_n),
        .vpa_n_o (vpa_n), .data_o (data), .data_oe_o (data_oe)
    );

    function automatic int lvl2idx(input logic [2:0] l);
        case (l)
            3'd7:    return 2;
            3'd5:    return 1;
            3'd3:    return 0;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [2:0] mask);
        @(negedge clk);
        evt = mask;
        @(negedge clk);
        evt = '0;
        pm  = pm | mask;
        chk(irq_n == ~pm, "R2 request lines", irq_n, ~pm);
    endtask

    task automatic do_ack(input logic [2:0] lvl, input logic [2:0] fcv,
                          input logic [2:0] late_mask, input logic [2:0] rel_mask);
        int  idx;
        bit  resp;
        bit  isauto;
        @(negedge clk);
        fc = fcv; addr = lvl; as_n = 1'b0;
        idx    = lvl2idx(lvl);
        resp   = (fcv == 3'b111) && (idx >= 0) && pm[idx];
        isauto = resp && am[idx];
        @(negedge clk);
        chk(vpa_n == !isauto, "R6/R3/R4 vpa after strobe fall", vpa_n, !isauto);
        chk(dtack_n == 1'b1, "R5 no dtack before lds", dtack_n, 1);
        evt   = late_mask;
        lds_n = 1'b0;
        @(negedge clk);
        evt = '0;
        pm  = pm | late_mask;
        chk(dtack_n == !(resp && !isauto), "R5/R4/R3 dtack with lds", dtack_n, !(resp && !isauto));
        chk(data_oe == (resp && !isauto), "R5/R6 data enable", data_oe, (resp && !isauto));
        if (resp && !isauto)
            chk(data == vc[idx*8 +: 8], "R5 vector value", data, vc[idx*8 +: 8]);
        chk(vpa_n == !isauto, "R6 vpa held", vpa_n, !isauto);
        chk(!( !dtack_n && !vpa_n), "R9 exclusive", {dtack_n, vpa_n}, 2'b11);
        as_n = 1'b1; lds_n = 1'b1; evt = rel_mask;
        @(negedge clk);
        evt = '0;
        if (resp) pm[idx] = 1'b0;
        pm = pm | rel_mask;
        chk(irq_n == ~pm, "R7/R8 lines after release", irq_n, ~pm);
        chk(dtack_n && vpa_n && !data_oe, "R9 negated after release", {dtack_n, vpa_n, data_oe}, 3'b110);
        fc = '0; addr = '0;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(irq_n == 3'b111, "R1 irq idle", irq_n, 3'b111);
        chk(dtack_n && vpa_n && !data_oe, "R1 handshake idle", {dtack_n, vpa_n, data_oe}, 3'b110);
        rst_n = 1'b1;
        am = 3'b010;
        vc = {8'h5A, 8'hC3, 8'h19};

        pulse_evt(3'b111);                        // R2 all three at once
        do_ack(3'd5, 3'b111, '0, '0);             // R6 auto, R7 others kept
        do_ack(3'd7, 3'b111, '0, '0);             // R5 vectored
        do_ack(3'd3, 3'b111, '0, '0);             // R5 vectored, slot 0
        pulse_evt(3'b100);
        do_ack(3'd7, 3'b110, '0, '0);             // R3 wrong function code
        do_ack(3'd4, 3'b111, '0, '0);             // R3 unused level code
        do_ack(3'd7, 3'b111, '0, '0);             // clears level 7
        do_ack(3'd5, 3'b111, 3'b010, '0);         // R4 pending arrives too late
        do_ack(3'd5, 3'b111, '0, '0);             // now served
        pulse_evt(3'b001);
        do_ack(3'd3, 3'b111, '0, 3'b001);         // R8 set wins over clear
        do_ack(3'd3, 3'b111, '0, '0);

        for (int it = 0; it < 300; it++) begin
            int op;
            logic [2:0] lv;
            op = $urandom % 5;
            case ($urandom % 4)
                0: lv = 3'd7;
                1: lv = 3'd5;
                2: lv = 3'd3;
                default: lv = 3'($urandom);
            endcase
            if (op == 0) pulse_evt(3'($urandom));
            else if (op == 4) begin
                @(negedge clk);
                am = 3'($urandom);
                vc = 24'($urandom);
            end else
                do_ack(lv, (($urandom % 8) == 0) ? 3'($urandom) : 3'b111,
                       (($urandom % 6) == 0) ? 3'($urandom) : 3'b000,
                       (($urandom % 6) == 0) ? 3'($urandom) : 3'b000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule